// File: doc/BRIEF.md
# Disk Rotational Position Timer

This block tracks where a head-per-track disk platter is under its heads. The angle is held as a word-slot counter that steps by one slot each interword period and wraps after one full track. The interword period is a programmable number of clocks. The counter drives an index window flag that is active over the first few slots of each revolution. When enabled, it also raises an index interrupt that stays pending until software clears the interrupt mask.

A transfer engine next to this block gives it a target word slot. The block reports, every cycle, how many word slots remain before the heads reach that target. While a transfer is armed, it pulses a slot strobe at the moment the heads arrive at the target. Register decoding and data movement are handled elsewhere.

Top module: `rot_position_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the position is 0, the prescaler is 0, and slotStrobe and indexIrq are low.
- R2: For an intervalCfg value N greater than zero, the position advances by exactly one every N clocks. Counted from reset release, after c rising edges the position is floor(c/N) modulo 2^POS_W.
- R3: The position wraps from 2^POS_W-1 to 0. With POS_W=11 that is 2047 to 0. It never changes by any step other than +1 modulo 2^POS_W.
- R4: indexActive is high exactly when the position is below INDEX_SLOTS (default 6).
- R5: When indexIrqEn is high during the clock edge that moves the position to 0, indexIrq becomes high in the same cycle the position reads 0. It then stays high until it is cleared.
- R6: A high maskClear during a clock edge makes indexIrq low after that edge. This clear takes priority over a set on the same edge.
- R7: When indexIrqEn is low, a wrap to position 0 does not set indexIrq.
- R8: waitWords equals target minus position. If that difference is negative, 2^POS_W is added to it.
- R9: slotStrobe is high for exactly one cycle: the first cycle in which the position equals target. The position must have advanced onto target at an edge where xferArm was high. There is no pulse when xferArm was low at that edge.
- R10: An intervalCfg of zero is treated as one, so the position advances on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intervalCfg | input | PRE_W | Clocks per word slot (0 behaves as 1) |
| indexIrqEn | input | 1 | Enables the once-per-revolution index interrupt |
| maskClear | input | 1 | Clears any pending index interrupt |
| xferArm | input | 1 | A transfer is waiting for its target slot |
| target | input | POS_W | Target word slot |
| position | output | POS_W | Current word slot under the heads |
| indexActive | output | 1 | Index window flag |
| indexIrq | output | 1 | Pending index interrupt |
| slotStrobe | output | 1 | One-cycle pulse on arrival at target while armed |
| waitWords | output | POS_W | Slots remaining until target |

## Verification
The hardest case to reach is a maskClear that lands on the same edge as the wrap that would set the index interrupt. The stimulus computes that edge from the interval and the revolution length and drives the clear in the cycle just before it, on alternate revolutions. A second, independent clear partway through each revolution exercises the plain clear path. The stimulus sweeps several intervals, including zero, and covers every possible target distance. It runs with the arm and enable inputs held both high and low.

// File: rtl/rot_pkg.sv
package rot_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic advance;   // step the position this edge
    logic irqClear;  // drop the pending index interrupt
  } rotCtl_t;

endpackage

// File: rtl/rot_ctrl.sv
module rot_ctrl
  import rot_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] intervalCfg,
  input  logic             maskClear,
  output rotCtl_t          ctl
);

  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] effInterval;
  logic             stepNow;

  // A zero interval is taken as one clock per slot
  assign effInterval = (intervalCfg == '0) ? ONE : intervalCfg;
  // >= keeps the prescaler bounded if the interval shrinks on the fly
  assign stepNow     = (preCnt >= (effInterval - ONE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (stepNow) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + ONE;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.advance  = rstN && stepNow;
    ctl.irqClear = maskClear;
  end

  // The prescaler never runs past the programmed interval for a stable setting
  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    $stable(intervalCfg) |-> (preCnt < effInterval)) else $error("prescaler overran"); // R2

endmodule

// File: rtl/rot_dp.sv
module rot_dp
  import rot_pkg::*;
#(
  parameter int POS_W       = 11,
  parameter int INDEX_SLOTS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  rotCtl_t          ctl,
  input  logic             indexIrqEn,
  input  logic             xferArm,
  input  logic [POS_W-1:0] target,
  output logic [POS_W-1:0] position,
  output logic             indexActive,
  output logic             indexIrq,
  output logic             slotStrobe,
  output logic [POS_W-1:0] waitWords
);

  localparam logic [POS_W-1:0] IDX_LIM = POS_W'(INDEX_SLOTS);
  localparam logic [POS_W-1:0] STEP    = POS_W'(1);

  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] posNext;
  logic             strobeQ;
  logic             irqQ;

  assign posNext = posQ + STEP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ    <= '0;
      strobeQ <= 1'b0;
    end else begin
      if (ctl.advance) begin
        posQ <= posNext;
      end
      strobeQ <= ctl.advance && xferArm && (posNext == target);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else if (ctl.irqClear) begin
      irqQ <= 1'b0;
    end else if (ctl.advance && indexIrqEn && (posNext == '0)) begin
      irqQ <= 1'b1;
    end
  end

  assign position    = posQ;
  assign indexActive = (posQ < IDX_LIM);
  assign indexIrq    = irqQ;
  assign slotStrobe  = strobeQ;
  assign waitWords   = target - posQ;   // modular distance

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (posQ != $past(posQ)) |-> (posQ == $past(posQ) + STEP)) else $error("bad step"); // R3
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> (posQ == '0)) else $error("irq off zero"); // R5
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.irqClear |=> !irqQ) else $error("irq survived clear"); // R6
  AST_STROBE_AT_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    slotStrobe |-> (posQ == $past(target))) else $error("strobe off target"); // R9
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    slotStrobe |=> !slotStrobe) else $error("strobe too long"); // R9

endmodule

// File: rtl/rot_position_timer.sv
module rot_position_timer
  import rot_pkg::*;
#(
  parameter int POS_W       = 11,
  parameter int PRE_W       = 8,
  parameter int INDEX_SLOTS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] intervalCfg,
  input  logic             indexIrqEn,
  input  logic             maskClear,
  input  logic             xferArm,
  input  logic [POS_W-1:0] target,
  output logic [POS_W-1:0] position,
  output logic             indexActive,
  output logic             indexIrq,
  output logic             slotStrobe,
  output logic [POS_W-1:0] waitWords
);

  rotCtl_t ctl;

  rot_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .intervalCfg (intervalCfg),
    .maskClear   (maskClear),
    .ctl         (ctl)
  );

  rot_dp #(.POS_W(POS_W), .INDEX_SLOTS(INDEX_SLOTS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .indexIrqEn  (indexIrqEn),
    .xferArm     (xferArm),
    .target      (target),
    .position    (position),
    .indexActive (indexActive),
    .indexIrq    (indexIrq),
    .slotStrobe  (slotStrobe),
    .waitWords   (waitWords)
  );

endmodule

// File: tb/rot_position_timer_bench.sv
module rot_position_timer_bench;

  localparam int POS_W = 5;
  localparam int PRE_W = 4;
  localparam int IDX   = 6;
  localparam int REV   = 1 << POS_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [PRE_W-1:0] intervalCfg = '0;
  logic             indexIrqEn = 1'b0;
  logic             maskClear = 1'b0;
  logic             xferArm = 1'b0;
  logic [POS_W-1:0] target = '0;
  logic [POS_W-1:0] position;
  logic             indexActive;
  logic             indexIrq;
  logic             slotStrobe;
  logic [POS_W-1:0] waitWords;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  rot_position_timer #(.POS_W(POS_W), .PRE_W(PRE_W), .INDEX_SLOTS(IDX)) u_rot_position_timer (
    .clk(clk), .rstN(rstN), .intervalCfg(intervalCfg), .indexIrqEn(indexIrqEn),
    .maskClear(maskClear), .xferArm(xferArm), .target(target), .position(position),
    .indexActive(indexActive), .indexIrq(indexIrq), .slotStrobe(slotStrobe),
    .waitWords(waitWords)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic runPhase(input int cfg, input bit en, input bit arm, input int tgt);
    int n;
    int e;
    bit expIrq;
    bit mcPrev;
    n = (cfg == 0) ? 1 : cfg;
    @(negedge clk);
    rstN = 1'b0; maskClear = 1'b0;
    intervalCfg = PRE_W'(cfg); indexIrqEn = en; xferArm = arm; target = POS_W'(tgt);
    @(negedge clk);
    // R1: outputs at rest while reset is held
    chk(position == 0 && !indexIrq && !slotStrobe, "R1", int'(position), 0);
    @(negedge clk);
    rstN = 1'b1;
    expIrq = 0; mcPrev = 0;
    for (int c = 0; c <= 3 * REV * n; c++) begin
      int expPos;
      bit changed;
      bit expStb;
      expPos  = (c / n) % REV;
      changed = (c > 0) && (c % n == 0);
      if (mcPrev) expIrq = 0;
      else if (en && changed && expPos == 0) expIrq = 1;
      expStb = arm && changed && (expPos == tgt);
      if (c == 0) chk(position == 0 && !indexIrq && !slotStrobe, "R1", int'(position), 0);
      chk(int'(position) == expPos, (cfg == 0) ? "R10" : "R2", int'(position), expPos);
      chk(indexActive == (expPos < IDX), "R4", int'(indexActive), int'(expPos < IDX));
      e = tgt - expPos; if (e < 0) e += REV;
      chk(int'(waitWords) == e, "R8", int'(waitWords), e);
      chk(slotStrobe == expStb, "R9", int'(slotStrobe), int'(expStb));
      chk(indexIrq == expIrq, en ? "R5_R6" : "R7", int'(indexIrq), int'(expIrq));
      // clear just before the wrap edge on odd revolutions, and mid-revolution
      maskClear = ((c % (REV * n)) == REV * n - 1 && ((c / (REV * n)) % 2 == 1)) ||
                  ((c % (REV * n)) == 10);
      mcPrev = maskClear;
      @(negedge clk);
    end
    maskClear = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    runPhase(1, 1, 1, 7);
    runPhase(2, 1, 0, 31);   // R3 wrap observed across three revolutions
    runPhase(3, 0, 1, 0);
    runPhase(0, 1, 1, 3);    // R10 zero interval
    runPhase(5, 1, 1, 20);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule